// File: doc/BRIEF.md
# Memory-Mapped GPIO Pad Controller

A bank of general-purpose I/O pads controlled over a plain 32-bit register bus. Every pad owns a 16-byte register window. The window holds a trigger/mux configuration word, a second configuration word, a value register and a default word. The value register carries active-low input and output enables and the pad level. The block drives pad outputs, samples pad inputs through a two-stage synchronizer, and detects rising, falling, both-edge, level-high and level-low events.

Detected events latch into sticky status bits. The status bits are packed 32 pads to a word in a separate status area, and software clears them by writing ones. A single interrupt line is the OR of every status bit. A bus access is a one-cycle request with `bus_valid_i`. Writes take effect at that clock edge. Read data is registered and is presented on `bus_rdata_o` after the edge that accepted the read.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every config0, config1 and default word reads 0, every value register reads 0x6 (both enables off, level 0), every status word reads 0, `irq_o` is low and no pad is driven.
- R2: Pad p's registers sit at byte address 16*p: config0 at +0x0, config1 at +0x4, value at +0x8 and default at +0xC. config1 and default hold any 32-bit value. config0 keeps only bits 26, 25, 24 and 2:0, and all other bits read 0. Read data appears on `bus_rdata_o` in the cycle after the read request.
- R3: Value bit 1 is an active-low output enable. While it is 0, `pad_oe_o[p]` is high and `pad_out_o[p]` equals the last written value bit 0. While it is 1, both outputs are low.
- R4: Value bit 0 reads back the stored output level when output is enabled. It reads the synchronized pad input when only input is enabled (bit 2 = 0, bit 1 = 1). It reads 0 when both enables are 1.
- R5: With config0 bit 25 set and bit 24 clear, a 0-to-1 pad transition sets the pad's status bit within three clock edges. A 1-to-0 transition does not set it.
- R6: With bit 26 set and bit 24 clear, a 1-to-0 transition sets the status bit. With both bits 25 and 26 set, either transition sets it.
- R7: With bit 24 set, bit 25 selects level-high and bit 26 selects level-low detection. While the active level persists, the status bit is set again on the cycle after it is cleared.
- R8: Status word k sits at 0x800 + 4*k, and bit j of that word belongs to pad 32*k + j. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. A status bit is set only by an event.
- R9: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: With config0 bits 24, 25 and 26 all clear, no pad activity sets that pad's status bit.
- R11: `irq_o` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PADS | Asynchronous pad inputs |
| pad_out_o | output | NUM_PADS | Pad output levels |
| pad_oe_o | output | NUM_PADS | Pad output enables, active high |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checker asserts on every cycle the following properties for every pad:
- A status bit only rises after an event and only falls after a clear.
- A coincident event beats the clear.
- A pad with all trigger bits off produces no event.
- An undriven pad shows a low output.
- The interrupt only rises after an event.

Only the bench scenarios can show the following:
- The address map.
- The trigger-mode semantics, including the reuse of the edge bits as level selectors.
- The three-edge input latency.
- The readback of the value register level bit.
- The re-setting of level status after a clear.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int REG_W   = 32;
  localparam int BIT_NEG = 26;
  localparam int BIT_POS = 25;
  localparam int BIT_LVL = 24;
  localparam int MUX_W   = 3;
  localparam int VAL_IEN = 2;
  localparam int VAL_OEN = 1;
  localparam int VAL_LEV = 0;

  typedef enum logic [1:0] {
    SLOT_CFG0 = 2'd0,
    SLOT_CFG1 = 2'd1,
    SLOT_VAL  = 2'd2,
    SLOT_DFLT = 2'd3
  } pad_slot_e;

  typedef struct packed {
    logic             trig_neg;
    logic             trig_pos;
    logic             trig_lvl;
    logic [MUX_W-1:0] mux;
  } cfg0_t;

  typedef struct packed {
    logic ien_n;
    logic oen_n;
    logic out_lvl;
  } val_t;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int N = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs import gpio_pad_pkg::*; #(
  parameter int N     = 40,
  parameter int IDX_W = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_pad_i,
  input  pad_slot_e             wr_slot_i,
  input  logic [REG_W-1:0]      wr_data_i,
  output cfg0_t [N-1:0]         cfg0_o,
  output logic [N-1:0][REG_W-1:0] cfg1_o,
  output logic [N-1:0][REG_W-1:0] dflt_o,
  output val_t [N-1:0]          val_o
);
  for (genvar p = 0; p < N; p++) begin : g_pad
    logic sel;
    assign sel = wr_en_i && (wr_pad_i == IDX_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg0_o[p] <= '0;
        cfg1_o[p] <= '0;
        dflt_o[p] <= '0;
        val_o[p]  <= '{ien_n: 1'b1, oen_n: 1'b1, out_lvl: 1'b0};
      end else if (sel) begin
        case (wr_slot_i)
          SLOT_CFG0: cfg0_o[p] <= '{trig_neg: wr_data_i[BIT_NEG],
                                    trig_pos: wr_data_i[BIT_POS],
                                    trig_lvl: wr_data_i[BIT_LVL],
                                    mux:      wr_data_i[MUX_W-1:0]};
          SLOT_CFG1: cfg1_o[p] <= wr_data_i;
          SLOT_VAL:  val_o[p]  <= '{ien_n:   wr_data_i[VAL_IEN],
                                    oen_n:   wr_data_i[VAL_OEN],
                                    out_lvl: wr_data_i[VAL_LEV]};
          default:   dflt_o[p] <= wr_data_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_pad_event.sv
module gpio_pad_event import gpio_pad_pkg::*; #(
  parameter int N = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg0_t [N-1:0] cfg0_i,
  input  logic [N-1:0]  sync_i,
  input  logic [N-1:0]  prev_i,
  input  logic [N-1:0]  clr_i,
  output logic [N-1:0]  evt_o,
  output logic [N-1:0]  status_o
);
  logic [N-1:0] status_q;

  for (genvar p = 0; p < N; p++) begin : g_det
    logic rise, fall, lvl_hit, edge_hit;
    always_comb begin
      rise     = sync_i[p] & ~prev_i[p];
      fall     = ~sync_i[p] & prev_i[p];
      lvl_hit  = (cfg0_i[p].trig_pos & sync_i[p]) | (cfg0_i[p].trig_neg & ~sync_i[p]);
      edge_hit = (cfg0_i[p].trig_pos & rise) | (cfg0_i[p].trig_neg & fall);
      evt_o[p] = cfg0_i[p].trig_lvl ? lvl_hit : edge_hit;
    end

    // event has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[p] <= 1'b0;
      else         status_q[p] <= (status_q[p] & ~clr_i[p]) | evt_o[p];
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl import gpio_pad_pkg::*; #(
  parameter int NUM_PADS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  input  logic [NUM_PADS-1:0] pad_in_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int IDX_W     = ADDR_W - 5;
  localparam int WORD_AW   = ADDR_W - 3;
  localparam int NUM_WORDS = (NUM_PADS + 31) / 32;

  logic                is_stat, pad_hit, wr_pad_en, wr_stat_en;
  logic [IDX_W-1:0]    pad_idx;
  logic [WORD_AW-1:0]  word_idx;
  pad_slot_e           slot;

  assign is_stat    = bus_addr_i[ADDR_W-1];
  assign pad_idx    = bus_addr_i[ADDR_W-2:4];
  assign word_idx   = bus_addr_i[ADDR_W-2:2];
  assign slot       = pad_slot_e'(bus_addr_i[3:2]);
  assign pad_hit    = !is_stat && ({1'b0, pad_idx} < (IDX_W+1)'(NUM_PADS));
  assign wr_pad_en  = bus_valid_i && bus_write_i && pad_hit;
  assign wr_stat_en = bus_valid_i && bus_write_i && is_stat;

  cfg0_t [NUM_PADS-1:0]            cfg0_q;
  logic  [NUM_PADS-1:0][REG_W-1:0] cfg1_q, dflt_q;
  val_t  [NUM_PADS-1:0]            val_q;
  logic  [NUM_PADS-1:0]            sync_q, prev_q, evt, clr, status;

  gpio_pad_regs #(.N(NUM_PADS), .IDX_W(IDX_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_pad_en),
    .wr_pad_i  (pad_idx),
    .wr_slot_i (slot),
    .wr_data_i (bus_wdata_i),
    .cfg0_o    (cfg0_q),
    .cfg1_o    (cfg1_q),
    .dflt_o    (dflt_q),
    .val_o     (val_q)
  );

  gpio_pad_sync #(.N(NUM_PADS)) sync_i (
    .clk_i, .rst_ni,
    .pad_i  (pad_in_i),
    .sync_o (sync_q),
    .prev_o (prev_q)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_clr
    assign clr[p] = wr_stat_en && (word_idx == WORD_AW'(p / 32)) && bus_wdata_i[p % 32];
    assign pad_oe_o[p]  = ~val_q[p].oen_n;
    assign pad_out_o[p] = ~val_q[p].oen_n & val_q[p].out_lvl;
  end

  gpio_pad_event #(.N(NUM_PADS)) event_i (
    .clk_i, .rst_ni,
    .cfg0_i   (cfg0_q),
    .sync_i   (sync_q),
    .prev_i   (prev_q),
    .clr_i    (clr),
    .evt_o    (evt),
    .status_o (status)
  );

  assign irq_o = |status;

  logic [NUM_WORDS*32-1:0] stat_ext;
  logic [REG_W-1:0]        rd_data;
  cfg0_t                   rd_cfg0;
  val_t                    rd_val;
  logic                    rd_lvl;

  always_comb begin
    stat_ext = '0;
    stat_ext[NUM_PADS-1:0] = status;
  end

  always_comb begin
    rd_data = '0;
    rd_cfg0 = cfg0_q[pad_idx];
    rd_val  = val_q[pad_idx];
    rd_lvl  = !rd_val.oen_n ? rd_val.out_lvl : (!rd_val.ien_n && sync_q[pad_idx]);
    if (is_stat) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (word_idx == WORD_AW'(w)) rd_data = stat_ext[w*32 +: 32];
    end else if (pad_hit) begin
      case (slot)
        SLOT_CFG0: begin
          rd_data[BIT_NEG]   = rd_cfg0.trig_neg;
          rd_data[BIT_POS]   = rd_cfg0.trig_pos;
          rd_data[BIT_LVL]   = rd_cfg0.trig_lvl;
          rd_data[MUX_W-1:0] = rd_cfg0.mux;
        end
        SLOT_CFG1: rd_data = cfg1_q[pad_idx];
        SLOT_VAL:  rd_data[2:0] = {rd_val.ien_n, rd_val.oen_n, rd_lvl};
        default:   rd_data = dflt_q[pad_idx];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         bus_rdata_o <= '0;
    else if (bus_valid_i && !bus_write_i) bus_rdata_o <= rd_data;
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk import gpio_pad_pkg::*; #(
  parameter int NUM_PADS = 40
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_o,
  input logic [NUM_PADS-1:0] pad_out_o,
  input logic [NUM_PADS-1:0] pad_oe_o,
  input cfg0_t [NUM_PADS-1:0] cfg0_q,
  input logic [NUM_PADS-1:0] evt,
  input logic [NUM_PADS-1:0] clr,
  input logic [NUM_PADS-1:0] status
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
    assert_set_by_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status[p]) |-> $past(evt[p]));
    assert_clear_by_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status[p]) |-> $past(clr[p]));
    assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[p] && evt[p]) |=> status[p]);
    assert_trig_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cfg0_q[p].trig_neg || cfg0_q[p].trig_pos || cfg0_q[p].trig_lvl) |-> !evt[p]);
    assert_undriven_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pad_oe_o[p] |-> !pad_out_o[p]);
  end

  assert_irq_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|evt));
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_PADS(NUM_PADS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .cfg0_q    (cfg0_q),
  .evt       (evt),
  .clr       (clr),
  .status    (status)
);

// File: tb/gpio_pad_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_tb_top;
  localparam int NP = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;
  int            total = 0, bad = 0;

  always #4 clk = ~clk;

  gpio_pad_ctrl #(.NUM_PADS(NP), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pa(input int p, input int slot);
    return AW'(p * 16 + slot * 4);
  endfunction
  function automatic logic [AW-1:0] sa(input int w);
    return AW'(32'h800 + 4 * w);
  endfunction
  function automatic logic [31:0] mode_cfg(input int m);
    case (m)
      1: return 32'h0200_0000;
      2: return 32'h0400_0000;
      3: return 32'h0600_0000;
      4: return 32'h0300_0000;
      5: return 32'h0500_0000;
      default: return 32'h0;
    endcase
  endfunction
  function automatic bit exp_evt(input int m, input bit o, input bit n);
    case (m)
      1: return !o && n;
      2: return o && !n;
      3: return o != n;
      4: return o || n;
      5: return !o || !n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_evt(input string req, input int p, input int m, input bit o, input bit n);
    logic [31:0] d;
    bit e;
    wr(pa(p, 0), 32'h0);
    pad_in[p] = o;
    idle(4);
    wr(sa(0), 32'hFFFF_FFFF);
    wr(sa(1), 32'hFFFF_FFFF);
    wr(pa(p, 0), mode_cfg(m) | ($urandom & 32'h7));
    @(negedge clk);
    pad_in[p] = n;
    idle(4);
    rd(sa(p / 32), d);
    e = exp_evt(m, o, n);
    chk(req, {31'd0, d[p % 32]}, {31'd0, e});
    chk("R11", {31'd0, irq}, {31'd0, e});
    wr(pa(p, 0), 32'h0);
    wr(sa(p / 32), 32'hFFFF_FFFF);
  endtask

  initial begin
    #(8ns * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1", {31'd0, irq}, 32'd0);
    chk("R1", {24'd0, 8'(pad_oe)}, 32'd0);
    rd(pa(5, 0), d); chk("R1", d, 32'h0);
    rd(pa(5, 1), d); chk("R1", d, 32'h0);
    rd(pa(5, 2), d); chk("R1", d, 32'h6);
    rd(pa(39, 3), d); chk("R1", d, 32'h0);
    rd(sa(0), d); chk("R1", d, 32'h0);
    rd(sa(1), d); chk("R1", d, 32'h0);

    // R2 address map
    wr(pa(3, 1), 32'hA5A5_1234);
    wr(pa(39, 3), 32'h0BAD_F00D);
    wr(pa(3, 0), 32'hFFFF_FFFF);
    rd(pa(3, 1), d); chk("R2", d, 32'hA5A5_1234);
    rd(pa(39, 3), d); chk("R2", d, 32'h0BAD_F00D);
    rd(pa(3, 0), d); chk("R2", d, 32'h0700_0007);
    rd(pa(4, 1), d); chk("R2", d, 32'h0);
    rd(pa(2, 0), d); chk("R2", d, 32'h0);
    wr(pa(3, 0), 32'h0);
    for (int i = 0; i < 20; i++) begin
      int p = $urandom_range(NP - 1);
      int s = ($urandom & 1) ? 3 : 1;
      v = $urandom;
      wr(pa(p, s), v);
      rd(pa(p, s), d);
      chk("R2", d, v);
    end

    // R3 / R4 value register
    wr(pa(7, 2), 32'h0);
    chk("R3", {30'd0, pad_oe[7], pad_out[7]}, 32'h2);
    wr(pa(7, 2), 32'h1);
    chk("R3", {30'd0, pad_oe[7], pad_out[7]}, 32'h3);
    rd(pa(7, 2), d); chk("R4", d, 32'h1);
    wr(pa(7, 2), 32'h3);
    chk("R3", {30'd0, pad_oe[7], pad_out[7]}, 32'h0);
    pad_in[7] = 1'b1; idle(3);
    rd(pa(7, 2), d); chk("R4", d, 32'h3);
    pad_in[7] = 1'b0; idle(3);
    rd(pa(7, 2), d); chk("R4", d, 32'h2);
    pad_in[7] = 1'b1; wr(pa(7, 2), 32'h7); idle(3);
    rd(pa(7, 2), d); chk("R4", d, 32'h6);
    pad_in[7] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      int p = $urandom_range(NP - 1);
      v = $urandom & 32'h7;
      wr(pa(p, 2), v);
      chk("R3", {30'd0, pad_oe[p], pad_out[p]}, {30'd0, !v[1], !v[1] && v[0]});
      wr(pa(p, 2), 32'h6);
    end

    // R5 / R6 / R7 / R10 / R8 directed modes
    run_evt("R5", 1, 1, 1'b0, 1'b1);
    run_evt("R5", 1, 1, 1'b1, 1'b0);
    run_evt("R6", 9, 2, 1'b1, 1'b0);
    run_evt("R6", 9, 2, 1'b0, 1'b1);
    run_evt("R6", 12, 3, 1'b0, 1'b1);
    run_evt("R6", 12, 3, 1'b1, 1'b0);
    run_evt("R7", 20, 4, 1'b0, 1'b1);
    run_evt("R7", 20, 5, 1'b1, 1'b0);
    run_evt("R7", 21, 4, 1'b0, 1'b0);
    run_evt("R10", 22, 0, 1'b0, 1'b1);
    run_evt("R10", 22, 0, 1'b1, 1'b0);
    run_evt("R8", 35, 1, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++)
      run_evt("R5", $urandom_range(NP - 1), $urandom_range(5), 1'($urandom), 1'($urandom));

    // R7 level status returns after clear
    pad_in[2] = 1'b1;
    wr(pa(2, 0), mode_cfg(4));
    idle(4);
    wr(sa(0), 32'h4);
    rd(sa(0), d); chk("R7", d & 32'h4, 32'h4);
    pad_in[2] = 1'b0; idle(4);
    wr(sa(0), 32'h4);
    rd(sa(0), d); chk("R7", d & 32'h4, 32'h0);
    wr(pa(2, 0), 32'h0);

    // R8 write-zero and other-bit writes leave the bit alone
    wr(pa(4, 0), mode_cfg(1));
    pad_in[4] = 1'b1; idle(4);
    wr(sa(0), 32'h0);
    rd(sa(0), d); chk("R8", d & 32'h10, 32'h10);
    wr(sa(0), 32'h20);
    rd(sa(0), d); chk("R8", d & 32'h10, 32'h10);
    wr(sa(1), 32'hFFFF_FFFF);
    rd(sa(0), d); chk("R8", d & 32'h10, 32'h10);
    wr(sa(0), 32'h10);
    rd(sa(0), d); chk("R8", d, 32'h0);
    chk("R11", {31'd0, irq}, 32'd0);
    wr(pa(4, 0), 32'h0);

    // R9 edge event coincides with clear
    wr(pa(6, 0), mode_cfg(1));
    pad_in[6] = 1'b0; idle(4);
    wr(sa(0), 32'hFFFF_FFFF);
    @(negedge clk); pad_in[6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = sa(0); wdata = 32'h40;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    rd(sa(0), d); chk("R9", d & 32'h40, 32'h40);
    chk("R11", {31'd0, irq}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule